// File: doc/BRIEF.md
# Fractional PLL Mode Register with Update Handshake

This block is the hardware side of the control word that steers a fractional PLL. Software reaches it through a small register port with three readable words: the mode word, a staged integer multiplier (L) and a staged fractional word (alpha). The mode word holds these fields:

- output enable, bypass release and an active-low PLL reset;
- an offline request;
- a vote enable and a vote reset;
- an update request and an update-bypass control;
- two 6-bit count fields.

Four status bits in the same word are driven by a behavioural PLL model: lock, active, offline acknowledge and latch acknowledge.

Lock is modelled as a delay after the reset bit is released while bypass release is set. The delay is the number of reference cycles held in the lock-count field. An update request copies the staged L and alpha words into the words the PLL runs on. It then answers with a latch acknowledge. By default, hardware clears the update request as soon as the acknowledge rises. With update-bypass set, software must clear the request itself, and the acknowledge falls only after it does so.

The handshake is a three-state machine: IDLE, LATCH and ACK.

- IDLE to LATCH happens when the update bit is seen; the staged words are captured on that same edge.
- LATCH to ACK happens unconditionally on the next edge.
- ACK to IDLE happens when update-bypass is clear, or when the update bit reads zero.

Top module: `pll_mode_ctl`

## Requirements
- R1: After reset, the mode word (address 0) reads 0x0000_0800, with the lock-count field (bits 13:8) at its default of 8 and every other bit zero. The latched L and alpha outputs read zero.
- R2: A write to address 0 stores only bits 0, 1, 2, 7 and 23:8 (mask 0x00FF_FF87). Bits 6:3 and 27:24 read zero. Status bits 31:28 ignore writes.
- R3: Lock (bit 31 and `lock_o`) asserts exactly N edges after the edge that sets the reset bit (bit 2) while bypass release (bit 1) is set, where N is the lock-count field. With bypass release clear, lock never asserts.
- R4: Lock drops in the cycle after the edge that clears the reset bit, with no delay.
- R5: The active flag (bit 30 and `active_o`) is lock ANDed with output enable (bit 0).
- R6: Offline acknowledge (bit 28) follows the offline request (bit 7) one edge later, both when it rises and when it falls.
- R7: When the update bit (bit 22) is set on edge E0, the staged L and alpha words appear on `l_word_o` and `alpha_word_o` after E0+1. Latch acknowledge (bit 29) rises after E0+2.
- R8: With update-bypass (bit 23) clear, the update bit and latch acknowledge both read zero after E0+3.
- R9: With update-bypass set, the update bit and the acknowledge stay high until software clears the update bit. The acknowledge then falls one edge after that write.
- R10: Writes to address 1 (L) and address 2 (alpha) are readable at once but do not change the latched outputs without an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 2 | Word select: 0 mode, 1 staged L, 2 staged alpha |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| lock_o | output | 1 | Modelled lock detect |
| active_o | output | 1 | Lock and output enable |
| l_word_o | output | 16 | L word in use by the PLL |
| alpha_word_o | output | 32 | Alpha word in use by the PLL |

## Verification
A handshake machine stuck in ACK or LATCH shows at the ports within three edges of an update write. Such a fault appears as a latch acknowledge or update bit that fails to clear, or as latched words that never change. A lock counter that is off by one moves the lock edge by one cycle, so lock and active are sampled both one cycle before and exactly at the programmed delay. Write-mask faults appear at the very next readback of the mode word.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
    localparam int B_OUTEN  = 0;
    localparam int B_BYPREL = 1;
    localparam int B_RSTN   = 2;
    localparam int B_OFFREQ = 7;
    localparam int FIELD_W  = 6;
    localparam int LCNT_LO  = 8;
    localparam int B_UPD    = 22;
    localparam int B_UPDBYP = 23;
    localparam int B_OFFACK = 28;
    localparam int B_LACK   = 29;
    localparam int B_ACT    = 30;
    localparam int B_LOCK   = 31;
    localparam logic [31:0] MODE_WR_MASK = 32'h00FF_FF87;
    localparam logic [1:0] A_MODE  = 2'd0;
    localparam logic [1:0] A_LVAL  = 2'd1;
    localparam logic [1:0] A_ALPHA = 2'd2;

    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_LATCH = 2'd1,
        UPD_ACK   = 2'd2
    } upd_state_e;
endpackage

// File: rtl/pll_lock_model.sv
module pll_lock_model #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    always_comb lock_o = run_i && (cnt_q >= limit_i);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && run_i && $stable(limit_i) && !$fell(run_i)) |=> (lock_o || !run_i || !$stable(limit_i)));
endmodule

// File: rtl/pll_update_fsm.sv
module pll_update_fsm
    import pll_mode_pkg::*;
#(
    parameter int L_W = 16,
    parameter int A_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           upd_i,
    input  logic           bypass_i,
    input  logic [L_W-1:0] l_pend_i,
    input  logic [A_W-1:0] a_pend_i,
    output logic           ack_o,
    output logic [L_W-1:0] l_word_o,
    output logic [A_W-1:0] a_word_o
);
    upd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UPD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  if (upd_i) state_d = UPD_LATCH;
            UPD_LATCH: state_d = UPD_ACK;
            UPD_ACK:   if (!bypass_i || !upd_i) state_d = UPD_IDLE;
            default:   state_d = UPD_IDLE;
        endcase
    end

    always_comb ack_o = (state_q == UPD_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_word_o <= '0;
            a_word_o <= '0;
        end else if (state_q == UPD_IDLE && upd_i) begin
            l_word_o <= l_pend_i;
            a_word_o <= a_pend_i;
        end
    end

    // R7
    ack_after_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(upd_i));
    // R10
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != UPD_IDLE) |=> $stable(l_word_o) && $stable(a_word_o));
endmodule

// File: rtl/pll_mode_ctl.sv
module pll_mode_ctl
    import pll_mode_pkg::*;
#(
    parameter int L_W          = 16,
    parameter int A_W          = 32,
    parameter int LOCK_DEFAULT = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    output logic           lock_o,
    output logic           active_o,
    output logic [L_W-1:0] l_word_o,
    output logic [A_W-1:0] alpha_word_o
);
    localparam logic [31:0] MODE_RST = 32'(LOCK_DEFAULT) << LCNT_LO;

    logic [31:0]    mode_q;
    logic [L_W-1:0] l_pend_q;
    logic [A_W-1:0] a_pend_q;
    logic           off_ack_q;
    logic           lack_w;
    logic           lock_w;
    logic           mode_wr;

    always_comb mode_wr = wr_en && (addr == A_MODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (mode_wr) begin
            mode_q <= wdata & MODE_WR_MASK;
        end else if (lack_w && !mode_q[B_UPDBYP]) begin
            mode_q[B_UPD] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_pend_q  <= '0;
            a_pend_q  <= '0;
            off_ack_q <= 1'b0;
        end else begin
            off_ack_q <= mode_q[B_OFFREQ];
            if (wr_en && addr == A_LVAL)  l_pend_q <= wdata[L_W-1:0];
            if (wr_en && addr == A_ALPHA) a_pend_q <= wdata[A_W-1:0];
        end
    end

    pll_lock_model #(.CNT_W(FIELD_W)) lock_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (mode_q[B_RSTN] && mode_q[B_BYPREL]),
        .limit_i (mode_q[LCNT_LO +: FIELD_W]),
        .lock_o  (lock_w)
    );

    pll_update_fsm #(.L_W(L_W), .A_W(A_W)) upd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_i    (mode_q[B_UPD]),
        .bypass_i (mode_q[B_UPDBYP]),
        .l_pend_i (l_pend_q),
        .a_pend_i (a_pend_q),
        .ack_o    (lack_w),
        .l_word_o (l_word_o),
        .a_word_o (alpha_word_o)
    );

    always_comb begin
        lock_o   = lock_w;
        active_o = lock_w && mode_q[B_OUTEN];
        unique case (addr)
            A_MODE: begin
                rdata = mode_q;
                rdata[B_OFFACK] = off_ack_q;
                rdata[B_LACK]   = lack_w;
                rdata[B_ACT]    = active_o;
                rdata[B_LOCK]   = lock_w;
            end
            A_LVAL:  rdata = 32'(l_pend_q);
            A_ALPHA: rdata = 32'(a_pend_q);
            default: rdata = '0;
        endcase
    end

    // R2
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> ((mode_q & ~MODE_WR_MASK) == 32'h0));
    // R4
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && !wdata[B_RSTN]) |=> !lock_o);
    // R6
    off_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_ack_q) |-> $past(mode_q[B_OFFREQ]));
    // R8
    upd_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lack_w && !mode_q[B_UPDBYP] && !mode_wr) |=> !mode_q[B_UPD]);
    // R9
    upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lack_w && mode_q[B_UPDBYP] && mode_q[B_UPD] && !mode_wr) |=> (mode_q[B_UPD] && lack_w));
endmodule

// File: tb/pll_mode_ctl_tb.sv
module pll_mode_ctl_tb_top;
    localparam int CLK_P = 10;
    localparam int NVEC  = 5;
    localparam logic [63:0] VEC [NVEC] = '{
        {32'hFFBF_FF78, 32'h00BF_FF00},
        {32'h0012_3400, 32'h0012_3400},
        {32'hF000_0000, 32'h0000_0000},
        {32'h0080_0800, 32'h0080_0800},
        {32'h5A0A_5A78, 32'h000A_5A00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        lock_o, active_o;
    logic [15:0] l_word_o;
    logic [31:0] alpha_word_o;
    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pll_mode_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lock_o(lock_o), .active_o(active_o),
        .l_word_o(l_word_o), .alpha_word_o(alpha_word_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 2'd0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(A_M(), v);
        check("R1 mode reset", v, 32'h0000_0800);
        check("R1 l_word reset", 32'(l_word_o), 32'h0);
        check("R1 alpha reset", alpha_word_o, 32'h0);

        // R2 write mask table
        for (int k = 0; k < NVEC; k++) begin
            wr(2'd0, VEC[k][63:32]);
            rd(2'd0, v);
            check("R2 mode mask", v, VEC[k][31:0]);
        end

        // R3 lock delay of 5
        wr(2'd0, 32'h0000_0502);
        wr(2'd0, 32'h0000_0506);
        cyc(4);
        check("R3 lock not yet", {31'h0, lock_o}, 32'h0);
        cyc(1);
        check("R3 lock at count", {31'h0, lock_o}, 32'h1);
        rd(2'd0, v);
        check("R3 lock bit31", 32'(v[31]), 32'h1);
        check("R5 inactive without outen", 32'(v[30]), 32'h0);
        // R5 active
        wr(2'd0, 32'h0000_0507);
        rd(2'd0, v);
        check("R5 active bit30", 32'(v[30]), 32'h1);
        check("R5 active_o", {31'h0, active_o}, 32'h1);
        // R4 drop on reset
        wr(2'd0, 32'h0000_0503);
        check("R4 lock drops", {31'h0, lock_o}, 32'h0);
        check("R4 active drops", {31'h0, active_o}, 32'h0);
        // R3 no bypass release
        wr(2'd0, 32'h0000_0504);
        cyc(10);
        check("R3 no lock without bypass release", {31'h0, lock_o}, 32'h0);

        // R6 offline handshake
        wr(2'd0, 32'h0000_0080);
        rd(2'd0, v);
        check("R6 ack not yet", 32'(v[28]), 32'h0);
        cyc(1);
        rd(2'd0, v);
        check("R6 ack raised", 32'(v[28]), 32'h1);
        wr(2'd0, 32'h0000_0000);
        rd(2'd0, v);
        check("R6 ack held one edge", 32'(v[28]), 32'h1);
        cyc(1);
        rd(2'd0, v);
        check("R6 ack dropped", 32'(v[28]), 32'h0);

        // R10 staged words
        wr(2'd1, 32'h0000_1234);
        wr(2'd2, 32'hDEAD_BEEF);
        rd(2'd1, v);
        check("R10 staged L readback", v, 32'h0000_1234);
        rd(2'd2, v);
        check("R10 staged alpha readback", v, 32'hDEAD_BEEF);
        check("R10 L not latched", 32'(l_word_o), 32'h0);
        check("R10 alpha not latched", alpha_word_o, 32'h0);

        // R7 / R8 auto-clear update
        wr(2'd0, 32'h0040_0000);
        rd(2'd0, v);
        check("R7 update bit set", v & 32'h6040_0000, 32'h0040_0000);
        check("R7 L not before E0+1", 32'(l_word_o), 32'h0);
        cyc(1);
        check("R7 L latched", 32'(l_word_o), 32'h0000_1234);
        check("R7 alpha latched", alpha_word_o, 32'hDEAD_BEEF);
        rd(2'd0, v);
        check("R7 ack not yet", 32'(v[29]), 32'h0);
        cyc(1);
        rd(2'd0, v);
        check("R7 ack raised", v & 32'h2040_0000, 32'h2040_0000);
        cyc(1);
        rd(2'd0, v);
        check("R8 update and ack cleared", v & 32'h2040_0000, 32'h0);

        // R9 update-bypass
        wr(2'd1, 32'h0000_0055);
        wr(2'd2, 32'h0000_0077);
        wr(2'd0, 32'h00C0_0000);
        cyc(2);
        rd(2'd0, v);
        check("R9 ack raised", v & 32'h2040_0000, 32'h2040_0000);
        check("R9 new L latched", 32'(l_word_o), 32'h0000_0055);
        cyc(3);
        rd(2'd0, v);
        check("R9 update and ack held", v & 32'h2040_0000, 32'h2040_0000);
        wr(2'd0, 32'h0080_0000);
        rd(2'd0, v);
        check("R9 update cleared ack still up", v & 32'h2040_0000, 32'h2000_0000);
        cyc(1);
        rd(2'd0, v);
        check("R9 ack dropped", v & 32'h2040_0000, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [1:0] A_M();
        return 2'd0;
    endfunction
endmodule